// File: doc/BRIEF.md
# SD Card Clock Generator with Timeout Counter

This block derives the SD card clock from the core clock through a programmable divider. The divider setting is an 11-bit value that holds the desired ratio minus two. The effective ratio depends on the transfer phase. During card identification (data-mode indication low) all bits of the setting are used. During data transfer only the low three bits count, which gives ratios from 2 to 9. A slow-card bit keeps the full-width ratio in force in data mode as well. The clock never stops, and the largest setting gives the slowest clock. Alongside the clock, the block emits a one-core-cycle enable strobe at each rising card-clock edge, so logic in the core domain can advance once per card clock.

The clock is produced by a two-state phase machine. `PH_HIGH` drives the card clock high for floor(N/2) core cycles. It then takes the transition high→low into `PH_LOW`, which holds the clock low for ceil(N/2) cycles. The transition low→high at the end of `PH_LOW` is the period boundary. It is the only point at which a new ratio is sampled, so a change to the setting cannot shorten or stretch a phase already under way. Reset places the machine at a boundary with a ratio of 2 loaded.

A timeout counter with states `TM_IDLE` and `TM_COUNT` sits next to the clock. A phase-start strobe takes it from either state into `TM_COUNT` with the 32-bit start value loaded. It counts down once per card-clock enable. An enable that arrives while the count is zero returns it to `TM_IDLE` and raises a one-cycle expiry pulse.

Top module: `cardclk_gen`

## Requirements
- R1: While reset is held, card_clk, clk_en and tmo_expired are all 0. Reset leaves the divider at a setting of 0, so the first period after reset with inputs div_cfg=0 and data_mode=0 is 1 cycle high and 1 cycle low.
- R2: With data_mode=0, the card clock period is div_cfg+2 core cycles for every 11-bit value of div_cfg.
- R3: With data_mode=1 and slow_card=0, the period is div_cfg[2:0]+2 core cycles, and bits 10..3 of div_cfg have no effect.
- R4: With data_mode=1 and slow_card=1, the period is div_cfg+2, the same as in identification mode.
- R5: Each period starts with a high phase of floor(N/2) core cycles, followed by a low phase of ceil(N/2) core cycles, where N is the period.
- R6: A change of div_cfg, slow_card or data_mode does not alter the period in progress. It takes effect from the next rising card-clock edge.
- R7: clk_en is 1 for exactly one core cycle per card period, namely the first core cycle in which card_clk is 1. It is never 1 on two consecutive cycles.
- R8: The setting 0x7FF gives the slowest clock, a 2049-cycle period with 1024 cycles high. The clock keeps toggling at every setting.
- R9: A phase_start pulse loads tmo_start. tmo_expired then pulses for one core cycle right after the (tmo_start+1)-th clk_en that follows the load. The clk_en of the load cycle itself is not counted.
- R10: After an expiry, tmo_expired stays 0 until a new phase_start. A phase_start during a countdown restarts it from the new start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_cfg | input | DIV_W (11) | Divider setting, ratio minus two |
| slow_card | input | 1 | Forces the full-width ratio in data mode |
| data_mode | input | 1 | 1 while in data transfer, 0 during identification |
| tmo_start | input | TMO_W (32) | Timeout start value |
| phase_start | input | 1 | Reloads the timeout counter at a command or data phase start |
| card_clk | output | 1 | Generated card clock |
| clk_en | output | 1 | One-cycle strobe at each rising card_clk |
| tmo_expired | output | 1 | One-cycle timeout expiry pulse |

## Verification
The bench builds the block with its default parameters: an 11-bit divider, a 3-bit data-mode field and a 32-bit timeout. This puts the 0x7FF slowest setting (2049-cycle period) and the bit-3 boundary between the data-mode and identification-mode ratios within direct reach. Random settings are drawn mostly from a small range, so that many periods of odd and even ratio are measured. Timeout start values are kept small, so expiry, the zero-start case and a reload during a countdown each complete within a few hundred card-clock periods.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef enum logic {
        TM_IDLE  = 1'b0,
        TM_COUNT = 1'b1
    } tmo_e;
endpackage

// File: rtl/cardclk_ratio_sel.sv
module cardclk_ratio_sel #(
    parameter int DIV_W     = 11,
    parameter int DATA_BITS = 3,
    localparam int RW       = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             slow_card,
    input  logic             data_mode,
    output logic [RW-1:0]    ratio
);
    logic [RW-1:0] wide_ratio;
    logic [RW-1:0] narrow_ratio;

    assign wide_ratio = RW'(div_cfg) + RW'(2);

    generate
        if (DATA_BITS >= DIV_W) begin : g_same
            assign narrow_ratio = wide_ratio;
        end else begin : g_narrow
            assign narrow_ratio = RW'(div_cfg[DATA_BITS-1:0]) + RW'(2);
        end
    endgenerate

    // identification mode or slow card: full setting; otherwise low bits only
    always_comb begin
        if (slow_card || !data_mode) ratio = wide_ratio;
        else                         ratio = narrow_ratio;
    end
endmodule

// File: rtl/cardclk_phase_fsm.sv
module cardclk_phase_fsm
    import cardclk_pkg::*;
#(
    parameter int RW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio_in,
    output logic          card_clk,
    output logic          clk_en
);
    phase_e        state_q, state_d;
    logic [RW-1:0] cnt_q, cnt_d;
    logic [RW-1:0] ratio_q, ratio_d;
    logic          clk_d, en_d;
    logic          boundary;

    assign boundary = (state_q == PH_LOW) && (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ratio_d = ratio_q;
        clk_d   = card_clk;
        en_d    = 1'b0;
        unique case (state_q)
            PH_LOW: begin
                if (cnt_q == '0) begin
                    // period boundary: sample the new ratio, go high
                    ratio_d = ratio_in;
                    state_d = PH_HIGH;
                    cnt_d   = (ratio_in >> 1) - RW'(1);
                    clk_d   = 1'b1;
                    en_d    = 1'b1;
                end else begin
                    cnt_d = cnt_q - RW'(1);
                end
            end
            PH_HIGH: begin
                if (cnt_q == '0) begin
                    state_d = PH_LOW;
                    cnt_d   = ratio_q - (ratio_q >> 1) - RW'(1);
                    clk_d   = 1'b0;
                end else begin
                    cnt_d = cnt_q - RW'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
            cnt_q   <= '0;
            ratio_q <= RW'(2);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_clk <= 1'b0;
            clk_en   <= 1'b0;
        end else begin
            card_clk <= clk_d;
            clk_en   <= en_d;
        end
    end

    // R7
    en_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> !clk_en);
    // R7
    en_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> clk_en);
    // R6
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(ratio_q));
    // R5
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HIGH) |-> (cnt_q < (ratio_q >> 1)));
    // R8
    ratio_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_q >= RW'(2));
endmodule

// File: rtl/cardclk_timeout.sv
module cardclk_timeout
    import cardclk_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [TMO_W-1:0] start_val,
    output logic             expired
);
    tmo_e             state_q, state_d;
    logic [TMO_W-1:0] count_q, count_d;
    logic             fire_d;

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        fire_d  = 1'b0;
        if (load) begin
            state_d = TM_COUNT;
            count_d = start_val;
        end else begin
            unique case (state_q)
                TM_IDLE: ;
                TM_COUNT: begin
                    if (tick) begin
                        if (count_q == '0) begin
                            state_d = TM_IDLE;
                            fire_d  = 1'b1;
                        end else begin
                            count_d = count_q - TMO_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) expired <= 1'b0;
        else        expired <= fire_d;
    end

    // R9
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
    // R10
    idle_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !$past(load)) |-> (state_q == TM_IDLE) || load);
    // R9
    fire_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(tick));
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen #(
    parameter int DIV_W     = 11,
    parameter int DATA_BITS = 3,
    parameter int TMO_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             slow_card,
    input  logic             data_mode,
    input  logic [TMO_W-1:0] tmo_start,
    input  logic             phase_start,
    output logic             card_clk,
    output logic             clk_en,
    output logic             tmo_expired
);
    localparam int RW = DIV_W + 1;

    logic [RW-1:0] ratio;

    cardclk_ratio_sel #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_sel (
        .div_cfg   (div_cfg),
        .slow_card (slow_card),
        .data_mode (data_mode),
        .ratio     (ratio)
    );

    cardclk_phase_fsm #(.RW(RW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_in (ratio),
        .card_clk (card_clk),
        .clk_en   (clk_en)
    );

    cardclk_timeout #(.TMO_W(TMO_W)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (clk_en),
        .load      (phase_start),
        .start_val (tmo_start),
        .expired   (tmo_expired)
    );
endmodule

// File: tb/cardclk_gen_test.sv
module cardclk_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] div_cfg = '0;
    logic        slow_card = 1'b0;
    logic        data_mode = 1'b0;
    logic [31:0] tmo_start = '0;
    logic        phase_start = 1'b0;
    logic        card_clk, clk_en, tmo_expired;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cardclk_gen uut (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .slow_card(slow_card),
        .data_mode(data_mode), .tmo_start(tmo_start), .phase_start(phase_start),
        .card_clk(card_clk), .clk_en(clk_en), .tmo_expired(tmo_expired)
    );

    function automatic int exp_ratio(int d, bit slow, bit dm);
        if (slow || !dm) return d + 2;
        return (d & 7) + 2;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // measure one card period; if wait_start, first move to the next clk_en
    task automatic measure(bit wait_start, output int h, output int l, output int extra_en);
        if (wait_start) begin
            do @(negedge clk); while (!clk_en);
        end
        h = 0; l = 0; extra_en = 0;
        while (card_clk) begin
            h++;
            @(negedge clk);
            if (clk_en && card_clk) extra_en++;
        end
        while (!card_clk) begin
            l++;
            if (clk_en) extra_en++;
            @(negedge clk);
        end
    endtask

    task automatic check_period(int d, bit slow, bit dm, string req);
        int h, l, x, n;
        n = exp_ratio(d, slow, dm);
        measure(1'b1, h, l, x);
        check(h + l == n, req, h + l, n);
        check(h == n / 2, "R5", h, n / 2);
        check(x == 0, "R7", x, 0);
    endtask

    task automatic tmo_run(int v, bit reload, int after, int v2, output int got);
        int n;
        bit pend;
        pend = reload;
        tmo_start = v;
        phase_start = 1'b1;
        @(negedge clk);
        phase_start = 1'b0;
        n = 0;
        got = -1;
        for (int i = 0; i < 4000; i++) begin
            if (tmo_expired) begin
                got = n;
                break;
            end
            if (clk_en) n++;
            if (pend && n == after) begin
                tmo_start = v2;
                phase_start = 1'b1;
                @(negedge clk);
                phase_start = 1'b0;
                n = 0;
                pend = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        int h, l, x, got, d;
        bit s, m;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        check(card_clk == 0 && clk_en == 0 && tmo_expired == 0, "R1",
              {card_clk, clk_en, tmo_expired}, 0);
        rst_n = 1'b1;
        measure(1'b1, h, l, x);
        check(h == 1 && l == 1, "R1", h * 10 + l, 11);

        // directed identification mode, even and odd ratios
        div_cfg = 11'd5;  check_period(5, 0, 0, "R2");
        div_cfg = 11'd12; check_period(12, 0, 0, "R2");
        // data mode: upper bits ignored
        data_mode = 1'b1;
        div_cfg = 11'd12; check_period(12, 0, 1, "R3");
        div_cfg = 11'h7F8; check_period(11'h7F8, 0, 1, "R3");
        div_cfg = 11'd7;  check_period(7, 0, 1, "R3");
        // slow card forces full setting
        slow_card = 1'b1;
        div_cfg = 11'd20; check_period(20, 1, 1, "R4");
        // slowest setting
        div_cfg = 11'h7FF; check_period(11'h7FF, 1, 1, "R8");
        slow_card = 1'b0; data_mode = 1'b0;
        check_period(11'h7FF, 0, 0, "R8");

        // change at a period start: current period keeps old ratio
        div_cfg = 11'd9;
        do @(negedge clk); while (!clk_en);
        do @(negedge clk); while (!clk_en);
        div_cfg = 11'd2;
        measure(1'b0, h, l, x);
        check(h + l == 11, "R6", h + l, 11);
        measure(1'b0, h, l, x);
        check(h + l == 4, "R6", h + l, 4);

        // random settings
        for (int i = 0; i < 24; i++) begin
            d = (i % 6 == 5) ? int'($urandom % 2048) : int'($urandom % 40);
            s = 1'($urandom);
            m = 1'($urandom);
            div_cfg = 11'(d); slow_card = s; data_mode = m;
            check_period(d, s, m, m && !s ? "R3" : "R2");
        end

        // timeout
        div_cfg = 11'd1; slow_card = 1'b0; data_mode = 1'b0;
        @(negedge clk);
        tmo_run(0, 0, 0, 0, got);  check(got == 1, "R9", got, 1);
        tmo_run(6, 0, 0, 0, got);  check(got == 7, "R9", got, 7);
        div_cfg = 11'd4;
        tmo_run(13, 0, 0, 0, got); check(got == 14, "R9", got, 14);
        // silence after expiry
        x = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (tmo_expired) x++;
        end
        check(x == 0, "R10", x, 0);
        // reload mid countdown
        tmo_run(20, 1, 5, 3, got); check(got == 4, "R10", got, 4);
        for (int i = 0; i < 6; i++) begin
            int v;
            v = int'($urandom % 16);
            div_cfg = 11'($urandom % 8);
            tmo_run(v, 0, 0, 0, got);
            check(got == v + 1, "R9", got, v + 1);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule